// File: doc/BRIEF.md
# Slow-Edge Input Qualifier

This block turns one asynchronous, slowly slewing input into a clean level that downstream state machines can use. Because such an input spends many clock periods inside the band where a receiver reads it as high or low at random, one raw sample of a new value is not enough. The block first passes the pin through a two-stage synchronizer. An idle/check state machine then accepts a new level only after it has seen that level on a parameterized number of consecutive clocks.

As soon as a candidate level appears, the block enables the pad's own output driver and drives the candidate value onto the pin. This pushes the edge through the undefined band. The driver is released again when verification ends, whether it succeeds or fails. Any sample that disagrees during verification sends the machine back to idle and leaves the accepted level as it was.

States: `ST_IDLE` (the accepted level is stable), `ST_CHECK_RISE` (a high candidate is being confirmed) and `ST_CHECK_FALL` (a low candidate is being confirmed). Transitions:
- *start* goes from idle to the matching check state when the synchronized sample differs from the accepted level.
- *confirm* stays in the check state on a matching sample that is not the last one.
- *accept* returns to idle on the final matching sample.
- *abort* returns to idle on any mismatching sample.

Top module: `slew_qualifier`

## Requirements
- R1: The pin reaches the logic only through two flip-flops clocked by `clk`. A pin change first held before clock edge e1 cannot affect any output before edge e1+2, which is when the check state and the pad enable can first react.
- R2: On the edge where the synchronized sample first differs from `level_o`, the machine enters a check state. On that same edge `pad_oe_o` goes to 1 and `pad_drive_o` takes the candidate value.
- R3: A new level is accepted only after CONFIRM_COUNT consecutive synchronized samples equal to the candidate, counting the sample that started the check. `level_o` changes on the edge of the last of those samples, which for a pin change held from edge e1 is edge e1+CONFIRM_COUNT+1.
- R4: A synchronized sample that differs from the candidate during a check (abort) returns the machine to idle. `level_o` stays unchanged and `pad_oe_o` goes to 0 on that same edge.
- R5: Qualification works the same way for low-to-high and high-to-low changes.
- R6: `change_o` is 1 for exactly the one cycle in which `level_o` has just taken a new value, and 0 at all other times.
- R7: `pad_oe_o` goes to 0 on the edge where a new level is accepted.
- R8: While `rst` is high at a clock edge, `level_o` and `pad_drive_o` are set to RESET_LEVEL, and `change_o` and `pad_oe_o` are set to 0.
- R9: While `pad_oe_o` is 1, `pad_drive_o` equals the inverse of `level_o` (the candidate). While `pad_oe_o` is 0, `pad_drive_o` equals `level_o`.
- R10: The confirmation counter is sized from CONFIRM_COUNT, so any value of 2 or more works, including 128 and above. Samples that equal `level_o` while idle leave all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | 1 | Raw asynchronous pad input |
| level_o | output | 1 | Qualified, registered level |
| change_o | output | 1 | One-cycle pulse when level_o takes a new value |
| pad_oe_o | output | 1 | Output enable for the pad driver |
| pad_drive_o | output | 1 | Value driven onto the pad when enabled |

## Verification
The hardest case to reach is an abort on the very last sample of a check: the pin must hold the candidate for exactly CONFIRM_COUNT-1 synchronized samples and then flip back. Random toggling almost never produces that. The stimulus therefore places directed runs one cycle short of the window, and also runs of exactly the window length. It then mixes in random slow-edge bursts, in which the pin chatters for a random number of cycles before settling. These bursts exercise restarts at every position in the window, in both directions.

// File: rtl/qual_pkg.sv
package qual_pkg;
    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_CHECK_RISE = 2'd1,
        ST_CHECK_FALL = 2'd2
    } qual_state_t;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= {STAGES{RESET_VAL}};
        else     pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/confirm_counter.sv
module confirm_counter #(
    parameter int TARGET = 32
) (
    input  logic clk,
    input  logic clr,
    input  logic load_one,
    input  logic inc,
    output logic at_last
);
    localparam int W = (TARGET < 2) ? 1 : $clog2(TARGET + 1);
    localparam logic [W-1:0] LAST = W'(TARGET - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (clr)           cnt <= '0;
        else if (load_one) cnt <= W'(1);
        else if (inc)      cnt <= cnt + W'(1);
    end

    assign at_last = (cnt == LAST);
endmodule

// File: rtl/qualifier_fsm.sv
module qualifier_fsm
    import qual_pkg::*;
#(
    parameter logic RESET_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic sample,
    input  logic at_last,
    output logic cnt_clr,
    output logic cnt_load,
    output logic cnt_inc,
    output logic level_o,
    output logic change_o,
    output logic pad_oe_o,
    output logic pad_drive_o
);
    qual_state_t state, nxt;
    logic start, confirm, accept, abort, cand;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // transitions
    always_comb begin
        nxt     = state;
        start   = 1'b0;
        confirm = 1'b0;
        accept  = 1'b0;
        abort   = 1'b0;
        cand    = level_o;
        unique case (state)
            ST_IDLE: begin
                if (sample != level_o) begin
                    start = 1'b1;
                    nxt   = sample ? ST_CHECK_RISE : ST_CHECK_FALL;
                end
            end
            ST_CHECK_RISE: begin
                cand = 1'b1;
                if (sample) begin
                    if (at_last) begin accept = 1'b1; nxt = ST_IDLE; end
                    else         confirm = 1'b1;
                end else begin
                    abort = 1'b1;
                    nxt   = ST_IDLE;
                end
            end
            ST_CHECK_FALL: begin
                cand = 1'b0;
                if (!sample) begin
                    if (at_last) begin accept = 1'b1; nxt = ST_IDLE; end
                    else         confirm = 1'b1;
                end else begin
                    abort = 1'b1;
                    nxt   = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign cnt_clr  = rst | accept | abort;
    assign cnt_load = start;
    assign cnt_inc  = confirm;

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            level_o     <= RESET_LEVEL;
            change_o    <= 1'b0;
            pad_oe_o    <= 1'b0;
            pad_drive_o <= RESET_LEVEL;
        end else begin
            change_o <= accept;
            if (accept) begin
                level_o     <= cand;
                pad_oe_o    <= 1'b0;
                pad_drive_o <= cand;
            end else if (abort) begin
                pad_oe_o    <= 1'b0;
                pad_drive_o <= level_o;
            end else if (start) begin
                pad_oe_o    <= 1'b1;
                pad_drive_o <= sample;
            end
        end
    end
endmodule

// File: rtl/slew_qualifier.sv
module slew_qualifier #(
    parameter int   CONFIRM_COUNT = 32,
    parameter logic RESET_LEVEL   = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_in,
    output logic level_o,
    output logic change_o,
    output logic pad_oe_o,
    output logic pad_drive_o
);
    localparam int SYNC_STAGES = 2;

    logic sample, at_last, cnt_clr, cnt_load, cnt_inc;

    sync_chain #(.STAGES(SYNC_STAGES), .RESET_VAL(RESET_LEVEL)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(sample)
    );

    confirm_counter #(.TARGET(CONFIRM_COUNT)) u_cnt (
        .clk(clk), .clr(cnt_clr), .load_one(cnt_load), .inc(cnt_inc),
        .at_last(at_last)
    );

    qualifier_fsm #(.RESET_LEVEL(RESET_LEVEL)) u_fsm (
        .clk(clk), .rst(rst), .sample(sample), .at_last(at_last),
        .cnt_clr(cnt_clr), .cnt_load(cnt_load), .cnt_inc(cnt_inc),
        .level_o(level_o), .change_o(change_o),
        .pad_oe_o(pad_oe_o), .pad_drive_o(pad_drive_o)
    );
endmodule

// File: rtl/slew_qualifier_checker.sv
module slew_qualifier_checker #(
    parameter logic RESET_LEVEL = 1'b0
) (
    input logic clk,
    input logic rst,
    input logic level_o,
    input logic change_o,
    input logic pad_oe_o,
    input logic pad_drive_o
);
    p_reset_state_r8: assert property (@(posedge clk)
        rst |=> (level_o == RESET_LEVEL && !change_o && !pad_oe_o));

    p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
        change_o |=> !change_o);

    p_level_move_flagged_r6: assert property (@(posedge clk) disable iff (rst)
        (level_o != $past(level_o)) |-> change_o);

    p_oe_released_on_accept_r7: assert property (@(posedge clk) disable iff (rst)
        change_o |-> !pad_oe_o);

    p_drive_candidate_r9: assert property (@(posedge clk) disable iff (rst)
        pad_oe_o |-> (pad_drive_o != level_o));

    p_drive_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !pad_oe_o |-> (pad_drive_o == level_o));

    p_abort_keeps_level_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(pad_oe_o) && !change_o) |-> $stable(level_o));

    p_start_keeps_level_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(pad_oe_o) |-> $stable(level_o));
endmodule

bind slew_qualifier slew_qualifier_checker #(.RESET_LEVEL(RESET_LEVEL)) u_chk (
    .clk(clk), .rst(rst), .level_o(level_o), .change_o(change_o),
    .pad_oe_o(pad_oe_o), .pad_drive_o(pad_drive_o)
);

// File: tb/tb_slew_qualifier.sv
module tb_slew_qualifier;
    localparam int   N   = 8;
    localparam logic RLV = 1'b0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin_in = RLV;
    logic level_o, change_o, pad_oe_o, pad_drive_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // model state
    logic m_q1, m_q2, m_lvl, m_chg;
    int   m_run;

    always #4 clk = ~clk;

    slew_qualifier #(.CONFIRM_COUNT(N), .RESET_LEVEL(RLV)) dut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .level_o(level_o),
        .change_o(change_o), .pad_oe_o(pad_oe_o), .pad_drive_o(pad_drive_o)
    );

    function automatic logic exp_oe();
        return m_run != 0;
    endfunction

    function automatic logic exp_drive();
        return (m_run != 0) ? ~m_lvl : m_lvl;
    endfunction

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    task automatic compare();
        check_bit("R1 R3 R5 level_o", level_o, m_lvl);
        check_bit("R6 change_o", change_o, m_chg);
        check_bit("R2 R4 R7 pad_oe_o", pad_oe_o, exp_oe());
        check_bit("R9 pad_drive_o", pad_drive_o, exp_drive());
    endtask

    // one edge of the reference behaviour
    task automatic model_step();
        logic s;
        if (rst) begin
            m_q1 = RLV; m_q2 = RLV; m_lvl = RLV; m_chg = 1'b0; m_run = 0;
            return;
        end
        s = m_q2;
        m_chg = 1'b0;
        if (s != m_lvl) begin
            m_run++;
            if (m_run == N) begin
                m_lvl = s; m_chg = 1'b1; m_run = 0;
            end
        end else begin
            m_run = 0;
        end
        m_q2 = m_q1;
        m_q1 = pin_in;
    endtask

    task automatic cycle(input logic v);
        @(negedge clk);
        compare();
        pin_in = v;
        @(posedge clk);
        model_step();
    endtask

    task automatic hold(input logic v, input int cycles);
        for (int i = 0; i < cycles; i++) cycle(v);
    endtask

    task automatic slow_edge(input logic target, input int band);
        for (int i = 0; i < band; i++) cycle(logic'($urandom % 2));
        hold(target, N + 4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        m_q1 = RLV; m_q2 = RLV; m_lvl = RLV; m_chg = 1'b0; m_run = 0;
        rst = 1'b1;
        repeat (3) begin @(posedge clk); model_step(); end
        @(negedge clk);
        rst = 1'b0;
        // R8: reset state
        check_bit("R8 reset level_o", level_o, RLV);
        check_bit("R8 reset pad_oe_o", pad_oe_o, 1'b0);
        check_bit("R8 reset change_o", change_o, 1'b0);
        @(posedge clk); model_step();

        hold(1'b0, 6);                 // R10: idle samples equal to level
        hold(1'b1, N + 6);             // R5 rise accepted
        hold(1'b0, N - 1);             // R4 abort on last sample
        hold(1'b1, 6);
        hold(1'b0, N);                 // R3 exactly the window
        hold(1'b0, 6);
        hold(1'b1, N - 1);             // R4 rise abort on last sample
        hold(1'b0, 4);
        hold(1'b1, 1);                 // single-cycle glitch
        hold(1'b0, 6);

        for (int k = 0; k < 200; k++)
            slow_edge(logic'(k % 2), 1 + int'($urandom % (2 * N)));
        for (int k = 0; k < 3000; k++)
            cycle(($urandom % 8 == 0) ? ~pin_in : pin_in);
        hold(pin_in, N + 4);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule